// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the engine of one DMA channel. Once software arms it, it walks a transfer one word per clock. It keeps a source pointer and a destination pointer, and each word advances both by four bytes. A per-pointer mask selects which address bits may change, so a narrow mask turns either pointer into a wrapping ring buffer. The block counts words against a total size and pulses an acknowledge on every word that closes a chunk. The block moves no data itself: its word strobe and pointers steer a separate bus engine, and descriptor values (pointers, masks, total size, chunk size) arrive on input ports.

A peripheral can pace the channel through a request input in handshake mode. The peripheral can also cut the current descriptor short through a next-descriptor input. When a descriptor ends, the sequencer can reload from a further chained descriptor, restart the same transfer, or finish. On finish it reports done, an optional remaining-size write-back and a masked interrupt. A stop request aborts the channel into an error state, with its own masked interrupt.

The first active cycle after arming is a set-up cycle that loads the descriptor; words move from the next active cycle on.

Top module: `dma_seq`

## Requirements
- R1: While the enable flag `en_o` is low, no word moves and the flags do not change; a `go_i` pulse sets `en_o` on the next edge and clears both interrupt flags.
- R2: An enabled channel with `halt_i` high clears `en_o` and `busy_o` and sets `err_o` on the next edge; no word moves in that cycle.
- R3: On a stop, if `ie_err_i` and `mask_a_i` are both high, `int_err_o` is set and `irq_o` pulses for one cycle with `irq_vec_o` equal to the one-hot bit at position `CH_IDX`; otherwise `irq_o` stays low.
- R4: In handshake mode (`hs_mode_i` high), the channel makes no progress in any cycle where `req_i` is low.
- R5: The first active cycle with `busy_o` low clears `done_o` and `err_o`, sets `busy_o` and loads both pointers from the descriptor inputs; `mv_o` stays low.
- R6: If `nd_i` is high in that first active cycle, the descriptor ends at once: with no chain reload and no restart, `done_o` is set, `busy_o` and `en_o` clear, and no interrupt is raised.
- R7: Every later active cycle pulses `mv_o` and advances each pointer to `(p & ~m) | ((p + 4) & m)` for its mask `m`, so bits outside the mask never change.
- R8: `ack_o` pulses together with `mv_o` on every word whose running count within the descriptor is a whole multiple of the chunk size.
- R9: When a descriptor ends with `chain_i` and `more_i` both high, the descriptor inputs are reloaded. Otherwise, if `auto_rst_i` is high, the transfer restarts from the same inputs. In both cases `busy_o` stays high and `done_o` stays low.
- R10: After the word that reaches the total size, with no reload, `done_o` is set and `err_o`, `busy_o` and `en_o` are cleared.
- R11: On such a normal completion, `int_done_o` is set and `irq_o` pulses with the channel bit only if `ie_done_i` and `mask_a_i` are both high.
- R12: `nd_i` high during a word cycle ends the descriptor after that word, without an interrupt.
- R13: A final end with `sz_wb_i` and `chain_i` both high pulses `wb_vld_o` with `wb_remain_o` equal to the total minus the words moved.
- R14: Total size and chunk size are captured at load; changes on those inputs during a transfer have no effect until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go_i | input | 1 | Arm pulse, sets the enable flag |
| halt_i | input | 1 | Stop request |
| hs_mode_i | input | 1 | Handshake mode select |
| req_i | input | 1 | Peripheral request |
| nd_i | input | 1 | Peripheral next-descriptor request |
| auto_rst_i | input | 1 | Restart transfer at its end |
| chain_i | input | 1 | Linked-list mode |
| more_i | input | 1 | Further chained descriptor pending |
| sz_wb_i | input | 1 | Remaining-size write-back enable |
| ie_done_i | input | 1 | Done interrupt enable |
| ie_err_i | input | 1 | Error interrupt enable |
| mask_a_i | input | 1 | This channel's bit of the interrupt mask |
| d_src_i | input | AW | Descriptor source pointer |
| d_smask_i | input | AW | Descriptor source step mask |
| d_dst_i | input | AW | Descriptor destination pointer |
| d_dmask_i | input | AW | Descriptor destination step mask |
| d_total_i | input | CW | Descriptor total size in words |
| d_chunk_i | input | CW | Descriptor chunk size in words |
| en_o | output | 1 | Enable flag |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer completed |
| err_o | output | 1 | Transfer stopped |
| int_done_o | output | 1 | Done interrupt flag |
| int_err_o | output | 1 | Error interrupt flag |
| irq_o | output | 1 | Interrupt pulse |
| irq_vec_o | output | NCH | One-hot channel bit while `irq_o` is high |
| mv_o | output | 1 | A word moved at the previous pointers |
| ack_o | output | 1 | Chunk completed |
| src_ptr_o | output | AW | Current source pointer |
| dst_ptr_o | output | AW | Current destination pointer |
| wb_vld_o | output | 1 | Size write-back pulse |
| wb_remain_o | output | CW | Remaining words for write-back |

## Verification
The bench builds the block with 32-bit pointers, an 8-bit word counter, four channels and channel index 2. The non-zero index shows that the interrupt vector places the bit by parameter and not at position zero. The 32-bit width lets one table row carry a pointer across the top of the address space. Step masks of 0xC on other rows bring four-word ring wraps within reach. The small chunk and total values make every-word acknowledges, odd chunk remainders and mid-transfer aborts short enough to check edge by edge.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
   localparam int STEP_BYTES = 4;

   typedef enum logic [1:0] {
      END_NONE   = 2'd0,
      END_RELOAD = 2'd1,
      END_FINAL  = 2'd2
   } seq_end_t;
endpackage

// File: rtl/dma_seq_ptr.sv
module dma_seq_ptr #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic [AW-1:0] base_i,
   input  logic [AW-1:0] mask_i,
   output logic [AW-1:0] ptr_o
);
   localparam logic [AW-1:0] INC = AW'(dma_seq_pkg::STEP_BYTES);

   logic [AW-1:0] ptr_q, mask_q, ptr_nx;

   // only bits under the mask take part in the step
   assign ptr_nx = (ptr_q & ~mask_q) | ((ptr_q + INC) & mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         mask_q <= '0;
      end else if (load) begin
         ptr_q  <= base_i;
         mask_q <= mask_i;
      end else if (step) begin
         ptr_q  <= ptr_nx;
      end
   end

   assign ptr_o = ptr_q;
endmodule

// File: rtl/dma_seq_cnt.sv
module dma_seq_cnt #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic [CW-1:0] total_i,
   input  logic [CW-1:0] chunk_i,
   output logic          last_o,
   output logic          hit_o,
   output logic [CW-1:0] cnt_o,
   output logic [CW-1:0] tot_o
);
   logic [CW-1:0] cnt_q, chk_q, tot_q, csz_q;
   logic [CW-1:0] cnt_nx, chk_nx;

   assign cnt_nx = cnt_q + 1'b1;
   assign chk_nx = chk_q + 1'b1;
   assign last_o = (cnt_nx >= tot_q);
   assign hit_o  = (chk_nx == csz_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         chk_q <= '0;
         tot_q <= '0;
         csz_q <= '0;
      end else if (load) begin
         cnt_q <= '0;
         chk_q <= '0;
         tot_q <= total_i;
         csz_q <= chunk_i;
      end else if (step) begin
         cnt_q <= cnt_nx;
         chk_q <= hit_o ? '0 : chk_nx;
      end
   end

   assign cnt_o = cnt_q;
   assign tot_o = tot_q;
endmodule

// File: rtl/dma_seq_ctl.sv
module dma_seq_ctl
   import dma_seq_pkg::*;
#(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_i,
   input  logic          halt_i,
   input  logic          hs_mode_i,
   input  logic          req_i,
   input  logic          nd_i,
   input  logic          auto_rst_i,
   input  logic          chain_i,
   input  logic          more_i,
   input  logic          sz_wb_i,
   input  logic          ie_done_i,
   input  logic          ie_err_i,
   input  logic          mask_a_i,
   input  logic          last_i,
   input  logic          hit_i,
   input  logic [CW-1:0] cnt_i,
   input  logic [CW-1:0] tot_i,
   input  logic [CW-1:0] d_total_i,
   output logic          load_o,
   output logic          step_o,
   output logic          en_o,
   output logic          busy_o,
   output logic          done_o,
   output logic          err_o,
   output logic          int_done_o,
   output logic          int_err_o,
   output logic          irq_o,
   output logic          mv_o,
   output logic          ack_o,
   output logic          wb_vld_o,
   output logic [CW-1:0] wb_remain_o
);
   logic en_q, busy_q, done_q, err_q, idone_q, ierr_q;
   logic irq_q, mv_q, ack_q, wbv_q;
   logic [CW-1:0] wbr_q;

   logic      stop, active, first, moving, ended, clean;
   seq_end_t  ecode;
   logic [CW-1:0] moved;

   assign stop   = en_q && halt_i;
   assign active = en_q && !halt_i && (!hs_mode_i || req_i);
   assign first  = active && !busy_q;
   assign moving = active && busy_q;
   assign ended  = (first && nd_i) || (moving && (nd_i || last_i));
   assign clean  = moving && !nd_i && last_i;

   always_comb begin
      ecode = END_NONE;
      if (ended) begin
         if ((chain_i && more_i) || auto_rst_i) ecode = END_RELOAD;
         else                                   ecode = END_FINAL;
      end
   end

   assign load_o = first || (ecode == END_RELOAD);
   assign step_o = moving;

   // words moved so far, counting the one in this cycle
   always_comb begin
      if (first)       moved = '0;
      else if (moving) moved = cnt_i + 1'b1;
      else             moved = cnt_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         idone_q <= 1'b0;
         ierr_q  <= 1'b0;
         irq_q   <= 1'b0;
         mv_q    <= 1'b0;
         ack_q   <= 1'b0;
         wbv_q   <= 1'b0;
         wbr_q   <= '0;
      end else begin
         irq_q <= 1'b0;
         wbv_q <= 1'b0;
         mv_q  <= moving;
         ack_q <= moving && hit_i;
         if (!en_q) begin
            if (go_i) begin
               en_q    <= 1'b1;
               idone_q <= 1'b0;
               ierr_q  <= 1'b0;
            end
         end else if (stop) begin
            en_q   <= 1'b0;
            busy_q <= 1'b0;
            err_q  <= 1'b1;
            if (ie_err_i && mask_a_i) begin
               ierr_q <= 1'b1;
               irq_q  <= 1'b1;
            end
         end else if (active) begin
            if (first) begin
               busy_q <= 1'b1;
               done_q <= 1'b0;
               err_q  <= 1'b0;
            end
            if (ecode == END_FINAL) begin
               en_q   <= 1'b0;
               busy_q <= 1'b0;
               done_q <= 1'b1;
               err_q  <= 1'b0;
               if (sz_wb_i && chain_i) begin
                  wbv_q <= 1'b1;
                  wbr_q <= (first ? d_total_i : tot_i) - moved;
               end
               if (clean && ie_done_i && mask_a_i) begin
                  idone_q <= 1'b1;
                  irq_q   <= 1'b1;
               end
            end
         end
      end
   end

   assign en_o        = en_q;
   assign busy_o      = busy_q;
   assign done_o      = done_q;
   assign err_o       = err_q;
   assign int_done_o  = idone_q;
   assign int_err_o   = ierr_q;
   assign irq_o       = irq_q;
   assign mv_o        = mv_q;
   assign ack_o       = ack_q;
   assign wb_vld_o    = wbv_q;
   assign wb_remain_o = wbr_q;
endmodule

// File: rtl/dma_seq.sv
module dma_seq #(
   parameter int AW     = 32,
   parameter int CW     = 8,
   parameter int NCH    = 4,
   parameter int CH_IDX = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           go_i,
   input  logic           halt_i,
   input  logic           hs_mode_i,
   input  logic           req_i,
   input  logic           nd_i,
   input  logic           auto_rst_i,
   input  logic           chain_i,
   input  logic           more_i,
   input  logic           sz_wb_i,
   input  logic           ie_done_i,
   input  logic           ie_err_i,
   input  logic           mask_a_i,
   input  logic [AW-1:0]  d_src_i,
   input  logic [AW-1:0]  d_smask_i,
   input  logic [AW-1:0]  d_dst_i,
   input  logic [AW-1:0]  d_dmask_i,
   input  logic [CW-1:0]  d_total_i,
   input  logic [CW-1:0]  d_chunk_i,
   output logic           en_o,
   output logic           busy_o,
   output logic           done_o,
   output logic           err_o,
   output logic           int_done_o,
   output logic           int_err_o,
   output logic           irq_o,
   output logic [NCH-1:0] irq_vec_o,
   output logic           mv_o,
   output logic           ack_o,
   output logic [AW-1:0]  src_ptr_o,
   output logic [AW-1:0]  dst_ptr_o,
   output logic           wb_vld_o,
   output logic [CW-1:0]  wb_remain_o
);
   localparam int NPTR = 2;
   localparam logic [NCH-1:0] CH_BIT = NCH'(1) << CH_IDX;

   if (AW < 3)                       begin : g_bad_aw  $error("AW must be at least 3"); end
   if (CW < 1)                       begin : g_bad_cw  $error("CW must be at least 1"); end
   if (CH_IDX < 0 || CH_IDX >= NCH)  begin : g_bad_idx $error("CH_IDX out of range"); end

   logic          load, step, last, hit;
   logic [CW-1:0] cnt, tot;
   logic [AW-1:0] base [NPTR];
   logic [AW-1:0] mask [NPTR];
   logic [AW-1:0] ptr  [NPTR];

   assign base[0] = d_src_i;
   assign mask[0] = d_smask_i;
   assign base[1] = d_dst_i;
   assign mask[1] = d_dmask_i;

   for (genvar g = 0; g < NPTR; g++) begin : g_ptr
      dma_seq_ptr #(.AW(AW)) u_ptr (
         .clk    (clk),
         .rst_n  (rst_n),
         .load   (load),
         .step   (step),
         .base_i (base[g]),
         .mask_i (mask[g]),
         .ptr_o  (ptr[g])
      );
   end

   assign src_ptr_o = ptr[0];
   assign dst_ptr_o = ptr[1];

   dma_seq_cnt #(.CW(CW)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .step    (step),
      .total_i (d_total_i),
      .chunk_i (d_chunk_i),
      .last_o  (last),
      .hit_o   (hit),
      .cnt_o   (cnt),
      .tot_o   (tot)
   );

   dma_seq_ctl #(.CW(CW)) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .go_i        (go_i),
      .halt_i      (halt_i),
      .hs_mode_i   (hs_mode_i),
      .req_i       (req_i),
      .nd_i        (nd_i),
      .auto_rst_i  (auto_rst_i),
      .chain_i     (chain_i),
      .more_i      (more_i),
      .sz_wb_i     (sz_wb_i),
      .ie_done_i   (ie_done_i),
      .ie_err_i    (ie_err_i),
      .mask_a_i    (mask_a_i),
      .last_i      (last),
      .hit_i       (hit),
      .cnt_i       (cnt),
      .tot_i       (tot),
      .d_total_i   (d_total_i),
      .load_o      (load),
      .step_o      (step),
      .en_o        (en_o),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .err_o       (err_o),
      .int_done_o  (int_done_o),
      .int_err_o   (int_err_o),
      .irq_o       (irq_o),
      .mv_o        (mv_o),
      .ack_o       (ack_o),
      .wb_vld_o    (wb_vld_o),
      .wb_remain_o (wb_remain_o)
   );

   assign irq_vec_o = irq_o ? CH_BIT : '0;
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
   parameter int AW  = 32,
   parameter int NCH = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           go_i,
   input logic           halt_i,
   input logic           hs_mode_i,
   input logic           req_i,
   input logic           mask_a_i,
   input logic           en_o,
   input logic           busy_o,
   input logic           err_o,
   input logic           irq_o,
   input logic [NCH-1:0] irq_vec_o,
   input logic           mv_o,
   input logic           ack_o,
   input logic [AW-1:0]  src_ptr_o
);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_o && !go_i) |=> (!mv_o && !busy_o && !en_o));

   p_halt_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_o && halt_i) |=> (!en_o && !busy_o && err_o && !mv_o));

   p_irq_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_vec_o) && (irq_o == (irq_vec_o != '0)));

   p_hs_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en_o && !halt_i && hs_mode_i && !req_i) |=> (!mv_o && $stable(src_ptr_o)));

   p_ack_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> mv_o);

   p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(mask_a_i));
endmodule

bind dma_seq dma_seq_chk #(.AW(AW), .NCH(NCH)) u_chk (.*);

// File: tb/sim_dma_seq.sv
module sim_dma_seq;
   localparam int  AW     = 32;
   localparam int  CW     = 8;
   localparam int  NCH    = 4;
   localparam int  CH_IDX = 2;
   localparam time CLK_P  = 10;

   typedef struct packed {
      logic [AW-1:0] src;
      logic [AW-1:0] smask;
      logic [AW-1:0] dst;
      logic [AW-1:0] dmask;
      logic [CW-1:0] tot;
      logic [CW-1:0] chunk;
      logic [AW-1:0] fsrc;
      logic [AW-1:0] fdst;
      logic [CW-1:0] nack;
   } vec_t;

   localparam vec_t TBL [4] = '{
      '{32'h0000_0100, 32'hFFFF_FFFC, 32'h0000_2100, 32'hFFFF_FFFC, 8'd4, 8'd2,
        32'h0000_0110, 32'h0000_2110, 8'd2},
      '{32'h0000_01F8, 32'h0000_000C, 32'h0000_11F8, 32'hFFFF_FFFC, 8'd4, 8'd3,
        32'h0000_01F8, 32'h0000_1208, 8'd1},
      '{32'h0000_0040, 32'hFFFF_FFFC, 32'h0000_3040, 32'hFFFF_FFFC, 8'd5, 8'd1,
        32'h0000_0054, 32'h0000_3054, 8'd5},
      '{32'hFFFF_FFF8, 32'hFFFF_FFFC, 32'h0000_0FF0, 32'h0000_000C, 8'd3, 8'd4,
        32'h0000_0004, 32'h0000_0FFC, 8'd0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic go_i = 0, halt_i = 0, hs_mode_i = 0, req_i = 0, nd_i = 0;
   logic auto_rst_i = 0, chain_i = 0, more_i = 0, sz_wb_i = 0;
   logic ie_done_i = 0, ie_err_i = 0, mask_a_i = 0;
   logic [AW-1:0] d_src_i = '0, d_smask_i = '0, d_dst_i = '0, d_dmask_i = '0;
   logic [CW-1:0] d_total_i = '0, d_chunk_i = '0;
   logic en_o, busy_o, done_o, err_o, int_done_o, int_err_o, irq_o, mv_o, ack_o, wb_vld_o;
   logic [NCH-1:0] irq_vec_o;
   logic [AW-1:0]  src_ptr_o, dst_ptr_o;
   logic [CW-1:0]  wb_remain_o;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   dma_seq #(.AW(AW), .CW(CW), .NCH(NCH), .CH_IDX(CH_IDX)) u0 (.*);

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_desc(input logic [AW-1:0] s, input logic [AW-1:0] sm,
                           input logic [AW-1:0] d, input logic [AW-1:0] dm,
                           input logic [CW-1:0] t, input logic [CW-1:0] c);
      d_src_i = s; d_smask_i = sm; d_dst_i = d; d_dmask_i = dm;
      d_total_i = t; d_chunk_i = c;
   endtask

   task automatic arm();
      go_i = 1'b1;
      tick();
      go_i = 1'b0;
   endtask

   initial begin
      #(CLK_P * 200000);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int words, acks;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk("R1 reset en", en_o, 0);
      chk("R1 reset busy", busy_o, 0);
      chk("R10 reset done", done_o, 0);
      chk("R7 reset mv", mv_o, 0);
      chk("R11 reset irq", irq_o, 0);

      // R1: idle, requests alone do nothing
      set_desc(32'h500, 32'hFFFF_FFFC, 32'h600, 32'hFFFF_FFFC, 8'd4, 8'd2);
      req_i = 1; nd_i = 1; halt_i = 1;
      repeat (4) tick();
      chk("R1 idle mv", mv_o, 0);
      chk("R1 idle busy", busy_o, 0);
      chk("R1 idle err", err_o, 0);
      chk("R1 idle ptr", src_ptr_o, 0);
      req_i = 0; nd_i = 0; halt_i = 0;

      // table of transfers: R7 pointer steps, R8 chunk acks, R10 completion
      for (int v = 0; v < 4; v++) begin
         set_desc(TBL[v].src, TBL[v].smask, TBL[v].dst, TBL[v].dmask, TBL[v].tot, TBL[v].chunk);
         arm();
         chk("R1 go sets en", en_o, 1);
         words = 0; acks = 0;
         for (int k = 0; k < 40; k++) begin
            tick();
            if (k == 0) begin
               chk("R5 load busy", busy_o, 1);
               chk("R5 load no move", mv_o, 0);
               chk("R5 load src", src_ptr_o, TBL[v].src);
            end
            if (mv_o)  words++;
            if (ack_o) acks++;
            if (done_o) break;
         end
         chk("R7 final src", src_ptr_o, TBL[v].fsrc);
         chk("R7 final dst", dst_ptr_o, TBL[v].fdst);
         chk("R7 word count", words, TBL[v].tot);
         chk("R8 ack count", acks, TBL[v].nack);
         chk("R10 done", done_o, 1);
         chk("R10 busy clear", busy_o, 0);
         chk("R10 en clear", en_o, 0);
         chk("R11 no irq unmasked", irq_o, 0);
      end

      // R11: done interrupt enabled and unmasked
      ie_done_i = 1; mask_a_i = 1;
      set_desc(32'h700, 32'hFFFF_FFFC, 32'h800, 32'hFFFF_FFFC, 8'd1, 8'd1);
      arm(); tick(); tick();
      chk("R11 done", done_o, 1);
      chk("R11 irq pulse", irq_o, 1);
      chk("R11 irq vec", irq_vec_o, 4'b0100);
      chk("R11 int flag", int_done_o, 1);
      tick();
      chk("R11 irq one cycle", irq_o, 0);
      // R11 masked
      mask_a_i = 0;
      arm(); tick(); tick();
      chk("R11 masked done", done_o, 1);
      chk("R11 masked irq", irq_o, 0);
      chk("R11 masked flag", int_done_o, 0);

      // R2/R3: stop with error interrupt
      ie_err_i = 1; mask_a_i = 1;
      set_desc(32'h900, 32'hFFFF_FFFC, 32'hA00, 32'hFFFF_FFFC, 8'd10, 8'd4);
      arm(); tick(); tick(); tick();
      halt_i = 1; tick(); halt_i = 0;
      chk("R2 stop en", en_o, 0);
      chk("R2 stop busy", busy_o, 0);
      chk("R2 stop err", err_o, 1);
      chk("R2 stop no move", mv_o, 0);
      chk("R3 err irq", irq_o, 1);
      chk("R3 err vec", irq_vec_o, 4'b0100);
      chk("R3 err flag", int_err_o, 1);
      // R5: restart clears error
      arm(); tick();
      chk("R5 err cleared", err_o, 0);
      chk("R5 done cleared", done_o, 0);
      chk("R1 go clears int flag", int_err_o, 0);

      // R4: handshake pacing, then stop without interrupt enable (R2/R3)
      halt_i = 1; tick(); halt_i = 0;
      ie_err_i = 0;
      hs_mode_i = 1; req_i = 0;
      set_desc(32'hB00, 32'hFFFF_FFFC, 32'hC00, 32'hFFFF_FFFC, 8'd8, 8'd2);
      arm(); tick(); tick(); tick();
      chk("R4 no load without req", busy_o, 0);
      req_i = 1; tick();
      chk("R4 load with req", src_ptr_o, 32'hB00);
      tick();
      chk("R4 move with req", src_ptr_o, 32'hB04);
      req_i = 0; tick(); tick();
      chk("R4 hold mv", mv_o, 0);
      chk("R4 hold ptr", src_ptr_o, 32'hB04);
      halt_i = 1; tick(); halt_i = 0;
      chk("R3 no err irq", irq_o, 0);
      chk("R3 no err flag", int_err_o, 0);
      chk("R2 err set", err_o, 1);
      hs_mode_i = 0;

      // R6: next-descriptor at first active cycle
      ie_done_i = 1; mask_a_i = 1;
      arm();
      nd_i = 1; tick(); nd_i = 0;
      chk("R6 done", done_o, 1);
      chk("R6 busy", busy_o, 0);
      chk("R6 no move", mv_o, 0);
      chk("R6 no irq", irq_o, 0);

      // R12/R13: next-descriptor mid transfer with size write-back
      chain_i = 1; more_i = 0; sz_wb_i = 1;
      set_desc(32'hD00, 32'hFFFF_FFFC, 32'hE00, 32'hFFFF_FFFC, 8'd10, 8'd4);
      arm(); tick(); tick(); tick();
      nd_i = 1; tick(); nd_i = 0;
      chk("R12 word moved", mv_o, 1);
      chk("R12 done", done_o, 1);
      chk("R12 no irq", irq_o, 0);
      chk("R13 wb pulse", wb_vld_o, 1);
      chk("R13 wb remain", wb_remain_o, 7);

      // R9/R14/R13: chained reload, then finish
      more_i = 1;
      set_desc(32'h300, 32'hFFFF_FFFC, 32'h400, 32'hFFFF_FFFC, 8'd2, 8'd1);
      arm(); tick();
      d_src_i = 32'h800; d_total_i = 8'd3;
      tick();
      chk("R7 chain word1", src_ptr_o, 32'h304);
      tick();
      chk("R14 ends at captured total", src_ptr_o, 32'h800);
      chk("R9 chain busy", busy_o, 1);
      chk("R9 chain not done", done_o, 0);
      chk("R13 no wb on reload", wb_vld_o, 0);
      more_i = 0;
      tick(); tick();
      chk("R14 new total captured", done_o, 0);
      tick();
      chk("R10 chain end done", done_o, 1);
      chk("R7 chain end src", src_ptr_o, 32'h80C);
      chk("R13 wb full", wb_vld_o, 1);
      chk("R13 wb zero", wb_remain_o, 0);
      chain_i = 0; sz_wb_i = 0; ie_done_i = 0;

      // R9: auto-restart
      auto_rst_i = 1;
      set_desc(32'h200, 32'hFFFF_FFFC, 32'h280, 32'hFFFF_FFFC, 8'd2, 8'd1);
      arm(); tick(); tick(); tick();
      chk("R9 restart src", src_ptr_o, 32'h200);
      chk("R9 restart busy", busy_o, 1);
      chk("R9 restart not done", done_o, 0);
      auto_rst_i = 0;
      tick(); tick();
      chk("R10 after restart done", done_o, 1);
      chk("R7 after restart src", src_ptr_o, 32'h208);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule